// File: doc/BRIEF.md
# Nanosecond-Period UART Sample Tick Generator

This block makes the 16x oversampling tick for a serial receiver and transmitter. It runs from a fixed system clock whose period is a parameter, 16 ns by default. Software does not program a count of clock cycles. It programs the wanted sample period as a time: an integer number of nanoseconds plus a fraction in steps of 1/255 ns. The block adds the clock period to a time accumulator on each cycle. When the accumulated time reaches the programmed period, it emits a one-cycle sample strobe and keeps the remainder. Every sixteenth sample strobe is also marked as a bit-time strobe.

A small state machine sets the phase of operation. `PH_IDLE` holds the accumulator at zero. `PH_TRACK` is the normal time-accumulating mode. `PH_SATURATE` is used when the programmed period is shorter than one clock, and it strobes on every cycle. The transitions are as follows. `IDLE->TRACK` happens on enable when the period is at least one clock. `IDLE->SATURATE` happens on enable when the period is shorter than one clock. `TRACK->IDLE` and `SATURATE->IDLE` happen when enable drops. A divisor write from any state goes to `IDLE` (the restart transition).

Top module: `nsbaud_gen`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, the divisor readback is 0 and both strobes are low.
- R2: A write loads all 32 divisor bits. The readback in the next cycle equals the written word, and it stays unchanged while no write occurs.
- R3: The divisor word is decoded as integer nanoseconds in bits 31:8 and a fraction x in bits 7:0 worth x/255 ns, giving the period P = int*255 + x in units of 1/255 ns. Each clock is counted as 16*255 = 4080 units. Take m as the number of cycles counted since the cycle in which the block left idle. A sample strobe is high after cycle m exactly when floor(m*4080/P) > floor((m-1)*4080/P).
- R4: The remainder is carried across strobes, so a fractional period produces a mixed pattern of short and long intervals whose long-run rate matches P.
- R5: The bit strobe is high only together with a sample strobe, on every 16th sample strobe counted since the last divisor write.
- R6: A divisor write clears the time accumulator and the sample count. No sample strobe appears in the cycle after the write or in the following idle-exit cycle.
- R7: If P is below 4080 (period under one clock, including 0), a sample strobe appears on every enabled cycle after the idle-exit cycle.
- R8: While enable is low, no strobes are emitted and the accumulator is held at zero, so timing restarts from m = 1 when enable returns. The sample count toward the bit strobe is kept.
- R9: A period of exactly one clock (P = 4080) gives a sample strobe on every cycle after the idle-exit cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, 16 ns period assumed by default |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Run enable; low holds the generator idle |
| wr_en | input | 1 | Divisor write strobe |
| wdata | input | 32 | Divisor write data (int ns in 31:8, fraction in 7:0) |
| rdata | output | 32 | Divisor readback |
| samp_stb | output | 1 | One-cycle oversampling strobe |
| bit_stb | output | 1 | One-cycle strobe on every 16th sample |

## Verification
The divisor is tried with five patterns. A realistic 115200-baud setting with a nonzero fraction checks that the remainder is carried over a long run and that two full bit periods come out. A whole-nanosecond period of several clocks checks plain accumulation. A period of about 1.5 clocks produces alternating one- and two-cycle gaps, which exposes a lost fraction or an off-by-one comparison. An exact one-clock period separates the boundary of the normal path from the clamp. Periods under one clock, including zero, exercise the saturating state. Dropping enable in the middle of a run and writing the divisor during a run show the difference between a phase that restarts and a sample count that is held or cleared.

// File: rtl/nsbaud_pkg.sv
package nsbaud_pkg;

    // Phase of the tick generator
    typedef enum logic [1:0] {
        PH_IDLE     = 2'd0,
        PH_TRACK    = 2'd1,
        PH_SATURATE = 2'd2
    } phase_e;

endpackage

// File: rtl/nsbaud_divreg.sv
module nsbaud_divreg #(
    parameter int DIV_W    = 32,
    parameter int FRAC_W   = 8,
    parameter int FRAC_DEN = 255,
    parameter int STEP     = 4080,
    parameter int ACC_W    = 33
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [DIV_W-1:0] wdata,
    output logic [DIV_W-1:0] div_q,
    output logic [ACC_W-1:0] target,
    output logic             fast
);

    always_ff @(posedge clk) begin
        if (!rst_n)
            div_q <= '0;
        else if (wr_en)
            div_q <= wdata;
    end

    // Period expressed in 1/FRAC_DEN ns units
    assign target = ACC_W'(div_q[DIV_W-1:FRAC_W]) * ACC_W'(FRAC_DEN)
                  + ACC_W'(div_q[FRAC_W-1:0]);

    // Period shorter than one clock
    assign fast = (target < ACC_W'(STEP));

endmodule

// File: rtl/nsbaud_phase.sv
module nsbaud_phase
    import nsbaud_pkg::*;
#(
    parameter int STEP  = 4080,
    parameter int ACC_W = 33
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             restart,
    input  logic [ACC_W-1:0] target,
    input  logic             fast,
    output logic             samp_stb
);

    phase_e           state_q, state_d;
    logic [ACC_W-1:0] acc_q, acc_d;
    logic [ACC_W-1:0] sum;
    logic             samp_d;

    always_comb begin
        sum     = acc_q + ACC_W'(STEP);
        state_d = state_q;
        acc_d   = acc_q;
        samp_d  = 1'b0;
        if (restart) begin
            state_d = PH_IDLE;
            acc_d   = '0;
        end else begin
            unique case (state_q)
                PH_IDLE: begin
                    acc_d = '0;
                    if (en)
                        state_d = fast ? PH_SATURATE : PH_TRACK;
                end
                PH_TRACK: begin
                    if (!en) begin
                        state_d = PH_IDLE;
                        acc_d   = '0;
                    end else if (sum >= target) begin
                        samp_d = 1'b1;
                        acc_d  = sum - target;
                    end else begin
                        acc_d = sum;
                    end
                end
                PH_SATURATE: begin
                    acc_d = '0;
                    if (!en)
                        state_d = PH_IDLE;
                    else
                        samp_d = 1'b1;
                end
                default: begin
                    state_d = PH_IDLE;
                    acc_d   = '0;
                end
            endcase
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= PH_IDLE;
        else
            state_q <= state_d;
    end

    // Datapath and output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q    <= '0;
            samp_stb <= 1'b0;
        end else begin
            acc_q    <= acc_d;
            samp_stb <= samp_d;
        end
    end

endmodule

// File: rtl/nsbaud_bitcnt.sv
module nsbaud_bitcnt #(
    parameter int OVS   = 16,
    parameter int CNT_W = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic samp_stb,
    output logic bit_stb
);

    logic [CNT_W-1:0] cnt_q;
    logic             last;

    assign last    = (cnt_q == CNT_W'(OVS - 1));
    assign bit_stb = samp_stb && last;

    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            cnt_q <= '0;
        else if (samp_stb)
            cnt_q <= last ? '0 : cnt_q + 1'b1;
    end

endmodule

// File: rtl/nsbaud_gen.sv
module nsbaud_gen #(
    parameter int DIV_W    = 32,
    parameter int FRAC_W   = 8,
    parameter int FRAC_DEN = 255,
    parameter int CLK_NS   = 16,
    parameter int OVS      = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             wr_en,
    input  logic [DIV_W-1:0] wdata,
    output logic [DIV_W-1:0] rdata,
    output logic             samp_stb,
    output logic             bit_stb
);

    localparam int STEP  = CLK_NS * FRAC_DEN;
    localparam int ACC_W = DIV_W + 1;
    localparam int CNT_W = (OVS > 1) ? $clog2(OVS) : 1;

    logic [ACC_W-1:0] target;
    logic             fast;

    nsbaud_divreg #(
        .DIV_W(DIV_W), .FRAC_W(FRAC_W), .FRAC_DEN(FRAC_DEN),
        .STEP(STEP), .ACC_W(ACC_W)
    ) u_divreg (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wdata(wdata),
        .div_q(rdata), .target(target), .fast(fast)
    );

    nsbaud_phase #(
        .STEP(STEP), .ACC_W(ACC_W)
    ) u_phase (
        .clk(clk), .rst_n(rst_n), .en(en), .restart(wr_en),
        .target(target), .fast(fast), .samp_stb(samp_stb)
    );

    nsbaud_bitcnt #(
        .OVS(OVS), .CNT_W(CNT_W)
    ) u_bitcnt (
        .clk(clk), .rst_n(rst_n), .clr(wr_en),
        .samp_stb(samp_stb), .bit_stb(bit_stb)
    );

endmodule

// File: rtl/nsbaud_gen_chk.sv
module nsbaud_gen_chk #(
    parameter int DIV_W    = 32,
    parameter int FRAC_W   = 8,
    parameter int FRAC_DEN = 255,
    parameter int CLK_NS   = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             en,
    input logic             wr_en,
    input logic [DIV_W-1:0] wdata,
    input logic [DIV_W-1:0] rdata,
    input logic             samp_stb,
    input logic             bit_stb
);

    localparam int STEP  = CLK_NS * FRAC_DEN;
    localparam int ACC_W = DIV_W + 1;

    logic [ACC_W-1:0] seen_period;
    assign seen_period = ACC_W'(rdata[DIV_W-1:FRAC_W]) * ACC_W'(FRAC_DEN)
                       + ACC_W'(rdata[FRAC_W-1:0]);

    p_readback_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (rdata == $past(wdata)));

    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(rdata));

    p_bit_with_sample_r5: assert property (@(posedge clk) disable iff (!rst_n)
        bit_stb |-> samp_stb);

    p_write_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !samp_stb);

    p_clamp_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !wr_en && $past(en) && !$past(wr_en) && $past(rst_n)
         && seen_period < ACC_W'(STEP)) |=> samp_stb);

    p_disabled_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !samp_stb);

    p_one_clock_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !wr_en && $past(en) && !$past(wr_en) && $past(rst_n)
         && seen_period == ACC_W'(STEP)) |=> samp_stb);

endmodule

bind nsbaud_gen nsbaud_gen_chk u_chk (
    .clk(clk), .rst_n(rst_n), .en(en), .wr_en(wr_en), .wdata(wdata),
    .rdata(rdata), .samp_stb(samp_stb), .bit_stb(bit_stb)
);

// File: tb/test_nsbaud_gen.sv
module test_nsbaud_gen;

    localparam longint STEP = 4080;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        samp_stb;
    logic        bit_stb;

    int total = 0;
    int bad   = 0;
    int scnt  = 0;

    always #4 clk = ~clk;

    nsbaud_gen i_nsbaud_gen (
        .clk(clk), .rst_n(rst_n), .en(en), .wr_en(wr_en), .wdata(wdata),
        .rdata(rdata), .samp_stb(samp_stb), .bit_stb(bit_stb)
    );

    task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, got, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    // Compare strobes against the arithmetic model for n cycles
    task automatic run_phase(input longint per, input int n, input string req);
        for (int m = 1; m <= n; m++) begin
            logic es;
            logic eb;
            tick();
            if (per < STEP)
                es = 1'b1;
            else
                es = ((longint'(m) * STEP) / per) != ((longint'(m - 1) * STEP) / per);
            if (es) scnt++;
            eb = es && (scnt % 16 == 0);
            check({req, " sample"}, samp_stb, es);
            check({req, " bit"}, bit_stb, eb);
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0; en = 1'b1;
        repeat (3) tick();
        check("R1 rdata in reset", rdata, 0);
        check("R1 sample in reset", samp_stb, 0);
        en = 1'b0; rst_n = 1'b1;
        tick();
        check("R1 rdata after reset", rdata, 0);
        check("R1 sample after reset", samp_stb, 0);
        check("R1 bit after reset", bit_stb, 0);
    endtask

    task automatic t_readback();
        en = 1'b0; wr_en = 1'b1; wdata = 32'hDEAD_BE11;
        tick();
        wr_en = 1'b0;
        check("R2 readback", rdata, 32'hDEAD_BE11);
        repeat (3) tick();
        check("R2 hold", rdata, 32'hDEAD_BE11);
        check("R8 idle sample", samp_stb, 0);
    endtask

    task automatic t_rate(input logic [31:0] d, input int n, input string req);
        longint per;
        per = longint'(d[31:8]) * 255 + longint'(d[7:0]);
        en = 1'b1; wr_en = 1'b1; wdata = d;
        tick();
        wr_en = 1'b0; scnt = 0;
        check("R2 readback after write", rdata, d);
        check("R6 sample after write", samp_stb, 0);
        check("R6 bit after write", bit_stb, 0);
        tick();
        check("R6 idle-exit cycle", samp_stb, 0);
        run_phase(per, n, req);
    endtask

    task automatic t_enable_gap();
        t_rate(32'h0000_6400, 70, "R3 pre-gap");
        en = 1'b0;
        for (int k = 0; k < 20; k++) begin
            tick();
            check("R8 disabled sample", samp_stb, 0);
            check("R8 disabled bit", bit_stb, 0);
        end
        en = 1'b1;
        tick();
        check("R8 re-enable exit cycle", samp_stb, 0);
        run_phase(25500, 150, "R8 resume");
    endtask

    initial begin
        t_reset();
        t_readback();
        t_rate(32'h0002_1E88, 1200, "R3 R4 R5 115200");
        t_rate(32'h0000_6400, 200, "R3 100ns");
        t_rate(32'h0000_1787, 200, "R4 fractional");
        t_rate(32'h0000_1000, 80, "R9 one clock");
        t_rate(32'h0000_0A00, 60, "R7 short period");
        t_rate(32'h0000_0000, 20, "R7 zero period");
        t_enable_gap();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(8 * 200000);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule